// File: doc/BRIEF.md
# Delta-Sigma ADC Register Access Master

This block is the configuration path to an external delta-sigma converter. Out of system reset it holds the converter's reset and start pins low, releases both, and waits out a fixed settling time. It then sends the single stop-continuous-read command so that later register reads return register contents and not conversion data. After that it serves a host, one request at a time. Each request carries an opcode, a start register, a register count and write data bytes. The block answers with read bytes and a done pulse.

Every transfer is one chip-select frame on a four-wire serial bus in clock-idle-low, second-edge-sample mode, sent most significant bit first. The block builds the converter's command bytes itself. The count byte holds the register count minus one. Read-back bytes are clocked out with 0xFF, never 0x00, because 0x00 is the wakeup command. Chip select stays low for a guard time after the last clock edge, then stays high for a minimum gap before the next frame. A divider register sets the serial clock rate and has a floor that keeps the clock under the converter's 2 MHz limit.

Top module: `dsadc_cfg_master`

## Requirements
- R1: After system reset, adcRstN and adcStart are held low for RST_LOW_CYCLES clocks while busy is high. Both then go high and stay high. csN is low only while both are high.
- R2: The first frame begins no earlier than POWERUP_CYCLES clocks after adcRstN rises. It consists of the single byte 0x16 and produces no done pulse.
- R3: A write request (reqOp 01) with start register r and count n (1 to 16) sends the byte {0100,r}, then the byte {0000,n-1}, then n data bytes taken from wrData. Each data byte consumed produces one wrTake pulse. Bits go MSB first, and MOSI changes only on SCLK rising edges.
- R4: A read request (reqOp 10) sends {0010,r}, then {0000,n-1}, then n bytes of 0xFF. A 0x00 byte never follows the count byte.
- R5: For a read, each data byte is assembled from MISO sampled on SCLK falling edges. The bytes are returned as n rdValid strobes on rdData, in ascending register order, while csN is still low.
- R6: SCLK idles low, changes only while csN is low, and is low when csN rises.
- R7: At least GUARD_CYCLES clocks pass between the last SCLK falling edge of a frame and csN rising.
- R8: Each SCLK high phase lasts D+1 clocks, where D is the divider. A divLoad pulse loads D from divValue only while busy is low. A value below MIN_DIV is raised to MIN_DIV. D is DIV_RESET after reset.
- R9: An accepted request raises busy in the next cycle. Requests and divider loads made while busy are ignored. done is a one-cycle pulse in the cycle busy falls.
- R10: These requests are ignored: reqOp 00, and reqOp 01 or 10 with a count of 0 or above 16. An ignored request starts no frame and gives no done, and busy stays low.
- R11: reqOp 11 sends the single-byte 0x16 frame again and ends with done.
- R12: csN stays high for at least GAP_CYCLES clocks between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqOp | input | 2 | 00 none, 01 write, 10 read, 11 stop continuous read |
| reqReg | input | 4 | Start register |
| reqCount | input | 5 | Number of registers, 1 to 16 |
| wrData | input | 8 | Next write data byte |
| wrTake | output | 1 | Pulse: current wrData byte consumed |
| divLoad | input | 1 | Load divider from divValue |
| divValue | input | DIV_W | Divider value |
| busy | output | 1 | Power-up or frame in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| rdValid | output | 1 | Read byte strobe |
| rdData | output | 8 | Read byte |
| adcRstN | output | 1 | Converter reset pin, active low |
| adcStart | output | 1 | Converter start pin |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |

## Verification
Every output is registered. A frame's bytes and chip-select timing therefore become visible only as pin edges, several divider periods after the request is accepted. The bench decodes those edges with a behavioural converter model that samples on the half cycle between clock edges. busy is due one clock after acceptance, and done and rdValid are due one clock after the state change behind them. So the bench waits for each event before it compares anything. Durations such as the SCLK high time, the guard time, the gap and the power-up wait are counted in whole clocks from the observed edges. They are checked either exactly or against a window of a few clocks above the bound.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  localparam int MAX_REGS   = 16;
  localparam int REG_ADDR_W = 4;
  localparam int REG_CNT_W  = 5;

  localparam logic [7:0] CMD_STOP_CONT = 8'h16;
  localparam logic [3:0] PFX_WRITE     = 4'b0100;
  localparam logic [3:0] PFX_READ      = 4'b0010;
  localparam logic [7:0] BYTE_DUMMY    = 8'hFF;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_STOPRD = 2'b11
  } hostOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       go;
    logic [7:0] txByte;
    logic       divLoad;
  } dpCtl_t;

endpackage

// File: rtl/dsadc_datapath.sv
module dsadc_datapath
  import dsadc_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int MIN_DIV   = 24,
  parameter int DIV_RESET = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [DIV_W-1:0] divValue,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             byteDone,
  output logic [7:0]       rxByte
);

  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] DIV_INIT  =
    DIV_W'((DIV_RESET < MIN_DIV) ? MIN_DIV : DIV_RESET);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] halfCnt;
  logic [2:0]       bitCnt;
  logic             active;
  logic             sclkR;
  logic             mosiR;
  logic             doneR;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic             halfTick;

  // divider register with a floor that keeps SCLK under its limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_INIT;
    end else if (ctl.divLoad) begin
      divReg <= (divValue < DIV_FLOOR) ? DIV_FLOOR : divValue;
    end
  end

  assign halfTick = active && (halfCnt == divReg);

  // one byte per go: rise shifts out, fall samples in
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      bitCnt  <= '0;
      active  <= 1'b0;
      sclkR   <= 1'b0;
      mosiR   <= 1'b0;
      doneR   <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
    end else begin
      doneR <= 1'b0;
      if (ctl.go) begin
        active  <= 1'b1;
        halfCnt <= '0;
        bitCnt  <= '0;
        txSh    <= ctl.txByte;
      end else if (active) begin
        if (halfTick) begin
          halfCnt <= '0;
          if (!sclkR) begin
            sclkR <= 1'b1;
            mosiR <= txSh[7];
            txSh  <= {txSh[6:0], 1'b0};
          end else begin
            sclkR  <= 1'b0;
            rxSh   <= {rxSh[6:0], miso};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              active <= 1'b0;
              doneR  <= 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  assign sclk     = sclkR;
  assign mosi     = mosiR;
  assign byteDone = doneR;
  assign rxByte   = rxSh;

endmodule

// File: rtl/dsadc_control.sv
module dsadc_control
  import dsadc_pkg::*;
#(
  parameter int RST_LOW_CYCLES = 100,
  parameter int POWERUP_CYCLES = 1700000,
  parameter int GUARD_CYCLES   = 180,
  parameter int GAP_CYCLES     = 50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqOp,
  input  logic [REG_ADDR_W-1:0] reqReg,
  input  logic [REG_CNT_W-1:0]  reqCount,
  input  logic [7:0]            wrData,
  input  logic                  divLoadReq,
  input  logic                  byteDone,
  input  logic [7:0]            rxByte,
  output dpCtl_t                ctl,
  output logic                  adcRstN,
  output logic                  adcStart,
  output logic                  csN,
  output logic                  busy,
  output logic                  done,
  output logic                  wrTake,
  output logic                  rdValid,
  output logic [7:0]            rdData
);

  localparam int MAX_A   = (RST_LOW_CYCLES > POWERUP_CYCLES) ? RST_LOW_CYCLES : POWERUP_CYCLES;
  localparam int MAX_B   = (GUARD_CYCLES > GAP_CYCLES) ? GUARD_CYCLES : GAP_CYCLES;
  localparam int TMR_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int IDX_W   = REG_CNT_W;

  localparam logic [TMR_W-1:0] RST_LAST   = TMR_W'(RST_LOW_CYCLES - 1);
  localparam logic [TMR_W-1:0] PWR_LAST   = TMR_W'(POWERUP_CYCLES - 1);
  localparam logic [TMR_W-1:0] GUARD_LAST = TMR_W'(GUARD_CYCLES - 1);
  localparam logic [TMR_W-1:0] GAP_LAST   = TMR_W'(GAP_CYCLES - 1);

  typedef enum logic [2:0] {
    ST_HOLD, ST_SETTLE, ST_IDLE, ST_LAUNCH, ST_SHIFT, ST_GUARD, ST_GAP
  } ctlState_e;

  ctlState_e             state;
  logic [TMR_W-1:0]      tmr;
  hostOp_e               opR;
  hostOp_e               opIn;
  logic [REG_ADDR_W-1:0] regR;
  logic [3:0]            cntM1R;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      lastIdx;
  logic                  userFrame;
  logic                  adcRstNR, adcStartR, csNR, doneR, wrTakeR, rdValidR;
  logic [7:0]            rdDataR;
  logic                  countOk;
  logic                  reqOk;
  logic [7:0]            frameByte;

  assign opIn    = hostOp_e'(reqOp);
  assign countOk = (reqCount != '0) && (reqCount <= REG_CNT_W'(MAX_REGS));
  assign reqOk   = reqValid && (state == ST_IDLE) && (opIn != OP_NOP) &&
                   ((opIn == OP_STOPRD) || countOk);

  // byte for the current frame position
  always_comb begin
    if (opR == OP_STOPRD) begin
      frameByte = CMD_STOP_CONT;
    end else if (idx == '0) begin
      frameByte = {(opR == OP_WRITE) ? PFX_WRITE : PFX_READ, regR};
    end else if (idx == IDX_W'(1)) begin
      frameByte = {4'b0000, cntM1R};
    end else begin
      frameByte = (opR == OP_WRITE) ? wrData : BYTE_DUMMY;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HOLD;
      tmr       <= '0;
      opR       <= OP_STOPRD;
      regR      <= '0;
      cntM1R    <= '0;
      idx       <= '0;
      lastIdx   <= '0;
      userFrame <= 1'b0;
      adcRstNR  <= 1'b0;
      adcStartR <= 1'b0;
      csNR      <= 1'b1;
      doneR     <= 1'b0;
      wrTakeR   <= 1'b0;
      rdValidR  <= 1'b0;
      rdDataR   <= '0;
    end else begin
      doneR    <= 1'b0;
      wrTakeR  <= 1'b0;
      rdValidR <= 1'b0;
      case (state)
        ST_HOLD: begin
          if (tmr == RST_LAST) begin
            tmr       <= '0;
            adcRstNR  <= 1'b1;
            adcStartR <= 1'b1;
            state     <= ST_SETTLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (tmr == PWR_LAST) begin
            tmr       <= '0;
            opR       <= OP_STOPRD;
            idx       <= '0;
            lastIdx   <= '0;
            userFrame <= 1'b0;
            csNR      <= 1'b0;
            state     <= ST_LAUNCH;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_IDLE: begin
          if (reqOk) begin
            opR       <= opIn;
            regR      <= reqReg;
            cntM1R    <= 4'(reqCount - 5'd1);
            lastIdx   <= (opIn == OP_STOPRD) ? '0 : reqCount + 5'd1;
            idx       <= '0;
            userFrame <= 1'b1;
            csNR      <= 1'b0;
            state     <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          wrTakeR <= (opR == OP_WRITE) && (idx >= IDX_W'(2));
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (byteDone) begin
            rdValidR <= (opR == OP_READ) && (idx >= IDX_W'(2));
            rdDataR  <= rxByte;
            if (idx == lastIdx) begin
              tmr   <= '0;
              state <= ST_GUARD;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_LAUNCH;
            end
          end
        end
        ST_GUARD: begin
          if (tmr == GUARD_LAST) begin
            tmr   <= '0;
            csNR  <= 1'b1;
            state <= ST_GAP;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_GAP: begin
          if (tmr == GAP_LAST) begin
            tmr   <= '0;
            doneR <= userFrame;
            state <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  assign ctl.go      = (state == ST_LAUNCH);
  assign ctl.txByte  = frameByte;
  assign ctl.divLoad = divLoadReq && (state == ST_IDLE);

  assign adcRstN  = adcRstNR;
  assign adcStart = adcStartR;
  assign csN      = csNR;
  assign busy     = (state != ST_IDLE);
  assign done     = doneR;
  assign wrTake   = wrTakeR;
  assign rdValid  = rdValidR;
  assign rdData   = rdDataR;

endmodule

// File: rtl/dsadc_cfg_master.sv
module dsadc_cfg_master
  import dsadc_pkg::*;
#(
  parameter int DIV_W          = 8,
  parameter int MIN_DIV        = 24,
  parameter int DIV_RESET      = 24,
  parameter int RST_LOW_CYCLES = 100,
  parameter int POWERUP_CYCLES = 1700000,
  parameter int GUARD_CYCLES   = 180,
  parameter int GAP_CYCLES     = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [3:0]       reqReg,
  input  logic [4:0]       reqCount,
  input  logic [7:0]       wrData,
  output logic             wrTake,
  input  logic             divLoad,
  input  logic [DIV_W-1:0] divValue,
  output logic             busy,
  output logic             done,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             adcRstN,
  output logic             adcStart,
  output logic             csN,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);

  dpCtl_t     ctl;
  logic       byteDone;
  logic [7:0] rxByte;

  dsadc_control #(
    .RST_LOW_CYCLES(RST_LOW_CYCLES),
    .POWERUP_CYCLES(POWERUP_CYCLES),
    .GUARD_CYCLES  (GUARD_CYCLES),
    .GAP_CYCLES    (GAP_CYCLES)
  ) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqReg    (reqReg),
    .reqCount  (reqCount),
    .wrData    (wrData),
    .divLoadReq(divLoad),
    .byteDone  (byteDone),
    .rxByte    (rxByte),
    .ctl       (ctl),
    .adcRstN   (adcRstN),
    .adcStart  (adcStart),
    .csN       (csN),
    .busy      (busy),
    .done      (done),
    .wrTake    (wrTake),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

  dsadc_datapath #(
    .DIV_W    (DIV_W),
    .MIN_DIV  (MIN_DIV),
    .DIV_RESET(DIV_RESET)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .divValue(divValue),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .byteDone(byteDone),
    .rxByte  (rxByte)
  );

endmodule

// File: rtl/dsadc_cfg_master_chk.sv
module dsadc_cfg_master_chk #(
  parameter int GUARD_CYCLES = 180
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic mosi,
  input logic adcRstN,
  input logic adcStart,
  input logic busy,
  input logic done,
  input logic rdValid
);

  logic [15:0] sinceFall;
  logic        sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceFall <= '0;
      sclkQ     <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (sclkQ && !sclk) begin
        sinceFall <= 16'd1;
      end else if (sinceFall != 16'hFFFF) begin
        sinceFall <= sinceFall + 16'd1;
      end
    end
  end

  AST_PINS_HIGH_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN) !csN |-> (adcRstN && adcStart)); // R1
  AST_MOSI_ON_RISE:       assert property (@(posedge clk) disable iff (!rstN) !$stable(mosi) |-> $rose(sclk)); // R3
  AST_RD_IN_FRAME:        assert property (@(posedge clk) disable iff (!rstN) rdValid |-> !csN); // R5
  AST_SCLK_ONLY_CS_LOW:   assert property (@(posedge clk) disable iff (!rstN) !$stable(sclk) |-> !csN); // R6
  AST_CS_RISE_SCLK_LOW:   assert property (@(posedge clk) disable iff (!rstN) $rose(csN) |-> !sclk); // R6
  AST_CS_GUARD:           assert property (@(posedge clk) disable iff (!rstN) $rose(csN) |-> (sinceFall >= 16'(GUARD_CYCLES))); // R7
  AST_FRAME_BUSY:         assert property (@(posedge clk) disable iff (!rstN) !csN |-> busy); // R9
  AST_DONE_NOT_BUSY:      assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R9
  AST_DONE_ONE_CYCLE:     assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R9

endmodule

bind dsadc_cfg_master dsadc_cfg_master_chk #(.GUARD_CYCLES(GUARD_CYCLES)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .sclk    (sclk),
  .mosi    (mosi),
  .adcRstN (adcRstN),
  .adcStart(adcStart),
  .busy    (busy),
  .done    (done),
  .rdValid (rdValid)
);

// File: tb/sim_dsadc_cfg_master.sv
`timescale 1ns/1ps
module sim_dsadc_cfg_master;

  localparam int RST_LOW = 20;
  localparam int PWR     = 300;
  localparam int GUARD   = 10;
  localparam int GAP     = 6;
  localparam int MIN_DIV = 1;
  localparam int DIV_RST = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqOp = 2'b00;
  logic [3:0] reqReg = 4'h0;
  logic [4:0] reqCount = 5'd0;
  logic [7:0] wrData;
  logic       wrTake;
  logic       divLoad = 1'b0;
  logic [7:0] divValue = 8'd0;
  logic       busy, done, rdValid;
  logic [7:0] rdData;
  logic       adcRstN, adcStart, csN, sclk, mosi;
  logic       miso = 1'b0;

  int checks = 0;
  int errors = 0;

  // monitor / converter model state
  int         cyc = 0;
  logic       pRst = 1'b0, pCs = 1'b1, pSclk = 1'b0;
  logic [7:0] regs [16];
  logic [7:0] fb [32];
  int         fLen = 0;
  int         bitN = 0;
  logic [7:0] curByte = 8'h00;
  logic [7:0] outByte = 8'h00;
  int         frames = 0;
  int         guardMeas = 0;
  int         sinceFall = 0;
  int         csHi = 0;
  int         minGap = 1000000;
  int         badEdges = 0;
  int         hiCnt = 0;
  int         lastHi = 0;
  logic [7:0] rdBuf [256];
  int         rdN = 0;
  int         wrIdx = 0;
  int         wrSeed = 0;
  int         doneCnt = 0;
  logic       busyAtDone = 1'b0;
  int         rstRiseCyc = -1;
  int         firstCsCyc = -1;
  int         resetRelCyc = 0;
  logic       sawCs = 1'b0;

  function automatic logic [7:0] pat(input int s, input int i);
    pat = 8'((s * 29 + i * 53 + 7) ^ (i * 8));
  endfunction

  assign wrData = pat(wrSeed, wrIdx);

  always #5 clk = ~clk;

  dsadc_cfg_master #(
    .DIV_W(8), .MIN_DIV(MIN_DIV), .DIV_RESET(DIV_RST),
    .RST_LOW_CYCLES(RST_LOW), .POWERUP_CYCLES(PWR),
    .GUARD_CYCLES(GUARD), .GAP_CYCLES(GAP)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqReg(reqReg),
    .reqCount(reqCount), .wrData(wrData), .wrTake(wrTake), .divLoad(divLoad),
    .divValue(divValue), .busy(busy), .done(done), .rdValid(rdValid), .rdData(rdData),
    .adcRstN(adcRstN), .adcStart(adcStart), .csN(csN), .sclk(sclk), .mosi(mosi),
    .miso(miso)
  );

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 8'(i * 17 + 3);
  end

  // pin monitor and behavioural converter, on the falling clock edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN) begin
      if (adcRstN && !pRst) rstRiseCyc = cyc;
      if (!csN && pCs) begin
        fLen = 0; bitN = 0; wrIdx = 0;
        if (!sawCs) firstCsCyc = cyc;
        sawCs = 1'b1;
        if (frames > 0 && csHi < minGap) minGap = csHi;
      end
      if (csN && !pCs) begin
        frames = frames + 1;
        guardMeas = sinceFall;
      end
      if (csN) csHi = csHi + 1; else csHi = 0;
      if ((sclk != pSclk) && csN) badEdges = badEdges + 1;
      if (sclk && !pSclk) miso = outByte[7 - bitN];
      if (!sclk && pSclk) begin
        lastHi = hiCnt;
        sinceFall = 0;
        curByte = {curByte[6:0], mosi};
        bitN = bitN + 1;
        if (bitN == 8) begin
          fb[fLen] = curByte;
          if (fLen >= 2 && fb[0][7:4] == 4'h4) regs[4'(int'(fb[0][3:0]) + fLen - 2)] = curByte;
          if (fb[0][7:4] == 4'h2) outByte = regs[4'(int'(fb[0][3:0]) + fLen - 1)];
          else outByte = 8'h00;
          fLen = fLen + 1;
          bitN = 0;
        end
      end else begin
        sinceFall = sinceFall + 1;
      end
      if (sclk) hiCnt = hiCnt + 1; else hiCnt = 0;
      if (rdValid) begin
        rdBuf[rdN[7:0]] = rdData;
        rdN = rdN + 1;
      end
      if (wrTake) wrIdx = wrIdx + 1;
      if (done) begin
        doneCnt = doneCnt + 1;
        busyAtDone = busy;
      end
    end
    pRst = adcRstN; pCs = csN; pSclk = sclk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic request(input logic [1:0] op, input logic [3:0] r, input logic [4:0] n);
    step();
    reqValid = 1'b1; reqOp = op; reqReg = r; reqCount = n;
    step();
    reqValid = 1'b0; reqOp = 2'b00;
  endtask

  task automatic waitDone(input int d0);
    while (doneCnt == d0) step();
    step();
  endtask

  task automatic loadDiv(input int d);
    step();
    divLoad = 1'b1; divValue = 8'(d);
    step();
    divLoad = 1'b0;
  endtask

  // one read with full frame and data checks
  task automatic doRead(input int r, input int n, input int seed, input bit usePat, input string tag);
    int d0, rb;
    bit frmOk, datOk;
    d0 = doneCnt; rb = rdN;
    request(2'b10, 4'(r), 5'(n));
    waitDone(d0);
    frmOk = (fLen == n + 2) && (fb[0] == {4'b0010, 4'(r)}) && (fb[1] == {4'b0000, 4'(n - 1)});
    for (int k = 0; k < n; k++) if (fb[k + 2] != 8'hFF || fb[k + 2] == 8'h00) frmOk = 1'b0;
    check(frmOk, {"R4 read frame ", tag}, fLen, n + 2);
    datOk = (rdN - rb == n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = usePat ? pat(seed, k) : 8'((((r + k) & 15) * 17) + 3);
      if (rdBuf[8'(rb + k)] != e) datOk = 1'b0;
    end
    check(datOk, {"R5 read data ", tag}, rdN - rb, n);
  endtask

  initial begin
    int d0, f0;
    bit ok;
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
    resetRelCyc = cyc;
    step();
    check(!adcRstN && !adcStart && busy, "R1 reset state pins low busy", {adcRstN, adcStart, busy}, 1);
    check(csN && !sclk, "R6 idle csN high sclk low", {csN, sclk}, 2);
    while (busy) step();
    check(rstRiseCyc - resetRelCyc >= RST_LOW && rstRiseCyc - resetRelCyc <= RST_LOW + 3,
          "R1 reset hold length", rstRiseCyc - resetRelCyc, RST_LOW);
    check(adcRstN && adcStart, "R1 pins high after power-up", {adcRstN, adcStart}, 3);
    check(firstCsCyc - rstRiseCyc >= PWR && firstCsCyc - rstRiseCyc <= PWR + 3,
          "R2 power-up wait", firstCsCyc - rstRiseCyc, PWR);
    check(frames == 1 && fLen == 1 && fb[0] == 8'h16, "R2 stop-read frame", int'(fb[0]), 'h16);
    check(doneCnt == 0, "R2 no done for initial frame", doneCnt, 0);

    // R8: divider sweep including clamp of 0 to MIN_DIV
    doRead(5, 1, 0, 1'b0, "default div");
    check(lastHi == DIV_RST + 1, "R8 reset divider high time", lastHi, DIV_RST + 1);
    for (int d = 0; d < 4; d++) begin
      loadDiv(d);
      doRead(d, 1, 0, 1'b0, "div sweep");
      check(lastHi == ((d < MIN_DIV) ? MIN_DIV : d) + 1, "R8 divider high time", lastHi,
            ((d < MIN_DIV) ? MIN_DIV : d) + 1);
    end
    loadDiv(1);

    // R3/R5: every register count, write then read back
    for (int n = 1; n <= 16; n++) begin
      int st;
      st = (n * 7) & 15;
      wrSeed = n;
      d0 = doneCnt;
      request(2'b01, 4'(st), 5'(n));
      check(busy, "R9 busy after accept", busy, 1);
      waitDone(d0);
      ok = (fLen == n + 2) && (fb[0] == {4'b0100, 4'(st)}) && (fb[1] == {4'b0000, 4'(n - 1)});
      for (int k = 0; k < n; k++) if (fb[k + 2] != pat(n, k)) ok = 1'b0;
      check(ok, "R3 write frame", fLen, n + 2);
      check(wrIdx == n, "R3 wrTake count", wrIdx, n);
      check(!busyAtDone && doneCnt == d0 + 1, "R9 done with busy low", doneCnt - d0, 1);
      check(guardMeas >= GUARD && guardMeas <= GUARD + 3, "R7 guard time", guardMeas, GUARD);
      doRead(st, n, n, 1'b1, "sweep");
    end

    // R8: divider load while busy is ignored
    d0 = doneCnt;
    request(2'b10, 4'h0, 5'd16);
    loadDiv(5);
    waitDone(d0);
    doRead(0, 1, 16, 1'b1, "after busy load");
    check(lastHi == 2, "R8 divider load ignored while busy", lastHi, 2);

    // R9: request while busy is ignored
    d0 = doneCnt; f0 = frames;
    request(2'b01, 4'h3, 5'd2);
    repeat (4) step();
    request(2'b10, 4'h9, 5'd4);
    waitDone(d0);
    repeat (200) step();
    check(frames == f0 + 1 && doneCnt == d0 + 1 && !busy, "R9 request during busy ignored",
          frames - f0, 1);

    // R10: invalid requests
    d0 = doneCnt; f0 = frames;
    request(2'b00, 4'h1, 5'd3);
    repeat (50) step();
    request(2'b10, 4'h1, 5'd0);
    repeat (50) step();
    request(2'b01, 4'h1, 5'd17);
    repeat (50) step();
    check(frames == f0 && doneCnt == d0 && !busy && csN, "R10 invalid requests ignored",
          frames - f0, 0);

    // R11: explicit stop-continuous-read
    d0 = doneCnt;
    request(2'b11, 4'h7, 5'd9);
    waitDone(d0);
    check(fLen == 1 && fb[0] == 8'h16 && doneCnt == d0 + 1, "R11 stop-read frame",
          int'(fb[0]), 'h16);

    check(minGap >= GAP, "R12 chip select gap", minGap, GAP);
    check(badEdges == 0, "R6 no SCLK edge with csN high", badEdges, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule